// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Register Block

This block is the register and interrupt front end of a two-channel serial controller. Channel A serves the console and channel B the auxiliary port. A processor reaches it through a simple memory-mapped bus with an address, a write-data byte, a read strobe, a write strobe and a registered read-data byte. It keeps one 8-bit interrupt status register and one 8-bit interrupt mask register. The bus can reach each of them as a whole or through a per-channel 4-bit window.

Each channel takes a byte at a time from a receive handshake and holds it in a one-entry buffer until software reads it. A write to the channel's transmit data register sends the byte out as a one-cycle strobe. A periodic tick input paces the transmit-ready interrupts: on every second tick both transmit-ready bits are raised together, provided that software has enabled either of them. A single interrupt request line goes high on any latched event. It drops only when software reads the channel A status register.

Top module: `duo_sio_irqctl`

## Requirements
- R1: After reset the interrupt status, the interrupt mask, the interrupt request, the read data, both pending flags and both transmit strobes are zero.
- R2: Address 0x3A0 reads and writes the whole 8-bit mask. Mask and status share this layout: bit 0 is A transmit ready, bit 1 is A receive ready, bit 4 is B transmit ready, bit 5 is B receive ready. Bits 2, 3, 6 and 7 of the status never become set.
- R3: A write to 0x330 replaces only mask bits 3:0, with write-data bits 3:0. A write to 0x350 moves write-data bits 3:0 into mask bits 7:4. In both cases the other nibble of the mask keeps its value. A read of either address returns its nibble in bits 3:0, with the upper bits zero.
- R4: A read of 0x390 returns the whole status byte. A read of 0x320 returns status bits 3:0. A read of 0x340 returns status bits 7:4 shifted down into bits 3:0.
- R5: When a byte arrives on a channel whose receive mask bit is set at that moment, the channel's receive status bit (bit 1 for A, bit 5 for B) and the interrupt request are set.
- R6: A byte that arrives while its receive mask bit is clear sets no status bit and does not raise the interrupt request. The byte is still held and marked pending.
- R7: A read of the receive data register (0x160 for A, 0x260 for B) returns the held byte and clears the pending flag and the receive status bit. A byte that arrives while another is still pending replaces it.
- R8: A write to the transmit data register (0x170 for A, 0x270 for B) produces a one-cycle strobe on that channel's transmit outputs carrying the write data, and clears that channel's transmit status bit (bit 0 for A, bit 4 for B).
- R9: A read of a channel status register (0x120 for A, 0x220 for B) returns bit 0 set when a byte is pending and bit 2 always set; all other bits are zero.
- R10: A read of the channel A status register clears the interrupt request. A read of the channel B status register leaves it unchanged.
- R11: Ticks are counted in pairs. The second tick of each pair sets both transmit status bits and the interrupt request, provided mask bit 0 or mask bit 4 is set. The first tick, and any tick while both of those mask bits are clear, change nothing.
- R12: Reads of unmapped or write-only addresses return zero. Writes to unmapped addresses change nothing.
- R13: When an event that sets a bit and an access that clears it fall in the same cycle, the set wins. This holds for a status bit and for the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, registered |
| rxa_valid | input | 1 | Channel A byte arrival |
| rxa_data | input | DATA_W | Channel A received byte |
| rxb_valid | input | 1 | Channel B byte arrival |
| rxb_data | input | DATA_W | Channel B received byte |
| txa_stb | output | 1 | Channel A transmit strobe |
| txa_data | output | DATA_W | Channel A transmit byte |
| txb_stb | output | 1 | Channel B transmit strobe |
| txb_data | output | DATA_W | Channel B transmit byte |
| tick | input | 1 | Periodic pacing tick |
| irq | output | 1 | Interrupt request |

## Verification
Every result comes out of one register stage. A read returns its data on the first clock edge after the strobe is sampled, and the data then holds until the next read. A write, a byte arrival or a tick shows its effect on status, mask, `irq` and the transmit strobe after that same single edge. The bench drives stimulus on the falling edge and samples at the next falling edge, so each value is taken exactly one edge after its cause. The transmit strobe is also checked one more cycle later to confirm it has fallen again. Same-cycle conflicts are built by driving the clearing access and the setting event in one cycle.

// File: rtl/duo_sio_pkg.sv
package duo_sio_pkg;
  // layout of each 4-bit lane in the status and mask registers
  localparam int LANE_W   = 4;
  localparam int BIT_TX   = 0;
  localparam int BIT_RX   = 1;
  // channel status bits
  localparam int CSR_PEND = 0;
  localparam int CSR_TXOK = 2;
  // address map
  localparam int OFF_ISR_ALL  = 'h390;
  localparam int OFF_IMR_ALL  = 'h3A0;
  localparam int OFF_ISR_LANE = 'h320;
  localparam int OFF_IMR_LANE = 'h330;
  localparam int LANE_STEP    = 'h20;
  localparam int CH_BASE      = 'h100;
  localparam int CH_STEP      = 'h100;
  localparam int OFF_CSR      = 'h20;
  localparam int OFF_RXD      = 'h60;
  localparam int OFF_TXD      = 'h70;
  // channel whose status read acknowledges the interrupt
  localparam int ACK_CH       = 0;
endpackage

// File: rtl/duo_sio_rx_hold.sv
module duo_sio_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic [DATA_W-1:0] held,
  output logic              pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      pending <= 1'b0;
    end else if (in_valid) begin
      held    <= in_data;
      pending <= 1'b1;
    end else if (take) begin
      pending <= 1'b0;
    end
  end

  // R7: a read with no new arrival leaves nothing pending
  p_take_clears_r7: assert property (@(posedge clk) disable iff (rst)
    take && !in_valid |=> !pending);
  // R13: an arrival dominates a same-cycle read
  p_arrival_wins_r13: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pending);
endmodule

// File: rtl/duo_sio_tick_pacer.sv
module duo_sio_tick_pacer #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic fire
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign fire = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R11: the counter stays inside its period
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R11: a firing tick restarts the count
  p_fire_restarts_r11: assert property (@(posedge clk) disable iff (rst)
    fire |=> cnt == '0);
endmodule

// File: rtl/duo_sio_irq_regs.sv
module duo_sio_irq_regs
  import duo_sio_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   mask_wr_all,
  input  logic [NCH-1:0]         mask_wr_lane,
  input  logic [NCH-1:0]         rx_arrive,
  input  logic [NCH-1:0]         rx_take,
  input  logic [NCH-1:0]         tx_take,
  input  logic                   tick_fire,
  input  logic                   irq_ack,
  output logic [NCH*LANE_W-1:0]  status,
  output logic [NCH*LANE_W-1:0]  mask,
  output logic                   irq
);
  localparam int STAT_W = NCH * LANE_W;

  logic [NCH-1:0]    rx_set, tx_en;
  logic [STAT_W-1:0] stat_nxt;
  logic              tx_set, set_any;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_lane
      localparam int RXB = g * LANE_W + BIT_RX;
      localparam int TXB = g * LANE_W + BIT_TX;
      assign rx_set[g] = rx_arrive[g] && mask[RXB];
      assign tx_en[g]  = mask[TXB];
      assign stat_nxt[RXB] = rx_set[g] || (status[RXB] && !rx_take[g]);
      assign stat_nxt[TXB] = tx_set    || (status[TXB] && !tx_take[g]);
      assign stat_nxt[g*LANE_W+LANE_W-1 : g*LANE_W+2] = '0;
    end
  endgenerate

  assign tx_set  = tick_fire && (|tx_en);
  assign set_any = (|rx_set) || tx_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= stat_nxt;
      if (mask_wr_all) mask <= wdata[STAT_W-1:0];
      for (int c = 0; c < NCH; c++)
        if (mask_wr_lane[c]) mask[c*LANE_W +: LANE_W] <= wdata[LANE_W-1:0];
      if (set_any)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  // R5: the request only rises on a latched event
  p_irq_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(set_any));
  // R10: an acknowledge with no new event drops the request
  p_ack_drops_irq_r10: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !set_any |=> !irq);
  // R6: a masked arrival on channel A latches nothing
  p_masked_rx_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    rx_arrive[0] && !mask[BIT_RX] && !status[BIT_RX] |=> !status[BIT_RX]);
  // R13: a set event keeps the request high despite an acknowledge
  p_set_beats_ack_r13: assert property (@(posedge clk) disable iff (rst)
    set_any |=> irq);
  // R2: reserved status bits never set
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status[3:2] == 2'b00);
endmodule

// File: rtl/duo_sio_irqctl.sv
module duo_sio_irqctl
  import duo_sio_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxa_valid,
  input  logic [DATA_W-1:0] rxa_data,
  input  logic              rxb_valid,
  input  logic [DATA_W-1:0] rxb_data,
  output logic              txa_stb,
  output logic [DATA_W-1:0] txa_data,
  output logic              txb_stb,
  output logic [DATA_W-1:0] txb_data,
  input  logic              tick,
  output logic              irq
);
  localparam int NCH    = 2;
  localparam int STAT_W = NCH * LANE_W;

  logic [NCH-1:0]    rx_v, rx_take, tx_hit, csr_rd, mask_wr_lane, pend;
  logic [DATA_W-1:0] rx_d [NCH];
  logic [DATA_W-1:0] held [NCH];
  logic [NCH-1:0]    tx_stb_q;
  logic [DATA_W-1:0] tx_dat_q [NCH];
  logic [STAT_W-1:0] status, mask;
  logic [DATA_W-1:0] rd_val;
  logic              tick_fire, mask_wr_all;

  assign rx_v    = {rxb_valid, rxa_valid};
  assign rx_d[0] = rxa_data;
  assign rx_d[1] = rxb_data;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      localparam int BASE = CH_BASE + g * CH_STEP;
      assign rx_take[g]      = bus_rd && (bus_addr == ADDR_W'(BASE + OFF_RXD));
      assign csr_rd[g]       = bus_rd && (bus_addr == ADDR_W'(BASE + OFF_CSR));
      assign tx_hit[g]       = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_TXD));
      assign mask_wr_lane[g] = bus_wr &&
                               (bus_addr == ADDR_W'(OFF_IMR_LANE + g * LANE_STEP));

      duo_sio_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_v[g]),
        .in_data  (rx_d[g]),
        .take     (rx_take[g]),
        .held     (held[g]),
        .pending  (pend[g])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          tx_stb_q[g] <= 1'b0;
          tx_dat_q[g] <= '0;
        end else begin
          tx_stb_q[g] <= tx_hit[g];
          if (tx_hit[g]) tx_dat_q[g] <= bus_wdata;
        end
      end

      // R8: every strobe answers a transmit write one cycle earlier
      p_tx_strobe_cause_r8: assert property (@(posedge clk) disable iff (rst)
        tx_stb_q[g] |-> $past(tx_hit[g]));
    end
  endgenerate

  assign mask_wr_all = bus_wr && (bus_addr == ADDR_W'(OFF_IMR_ALL));

  duo_sio_tick_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .fire (tick_fire)
  );

  duo_sio_irq_regs #(.NCH(NCH), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wdata        (bus_wdata),
    .mask_wr_all  (mask_wr_all),
    .mask_wr_lane (mask_wr_lane),
    .rx_arrive    (rx_v),
    .rx_take      (rx_take),
    .tx_take      (tx_hit),
    .tick_fire    (tick_fire),
    .irq_ack      (csr_rd[ACK_CH]),
    .status       (status),
    .mask         (mask),
    .irq          (irq)
  );

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFF_ISR_ALL)) rd_val = DATA_W'(status);
    if (bus_addr == ADDR_W'(OFF_IMR_ALL)) rd_val = DATA_W'(mask);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(OFF_ISR_LANE + c * LANE_STEP))
        rd_val = DATA_W'(status[c*LANE_W +: LANE_W]);
      if (bus_addr == ADDR_W'(OFF_IMR_LANE + c * LANE_STEP))
        rd_val = DATA_W'(mask[c*LANE_W +: LANE_W]);
      if (bus_addr == ADDR_W'(CH_BASE + c * CH_STEP + OFF_CSR)) begin
        rd_val = '0;
        rd_val[CSR_PEND] = pend[c];
        rd_val[CSR_TXOK] = 1'b1;
      end
      if (bus_addr == ADDR_W'(CH_BASE + c * CH_STEP + OFF_RXD))
        rd_val = held[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign txa_stb  = tx_stb_q[0];
  assign txb_stb  = tx_stb_q[1];
  assign txa_data = tx_dat_q[0];
  assign txb_data = tx_dat_q[1];

  // R8: the strobe lasts one cycle unless a second write follows
  p_tx_single_r8: assert property (@(posedge clk) disable iff (rst)
    txa_stb && !$past(tx_hit[0], 1) |-> 1'b0);
  // R10: a channel B status read alone does not drop the request
  p_b_read_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    irq && csr_rd[1] && !csr_rd[0] |=> irq);
endmodule

// File: tb/duo_sio_irqctl_bench.sv
module duo_sio_irqctl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;
  logic        rxa_valid, rxb_valid;
  logic [7:0]  rxa_data, rxb_data;
  logic        txa_stb, txb_stb;
  logic [7:0]  txa_data, txb_data;
  logic        tick, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  duo_sio_irqctl u_duo_sio_irqctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rxa_valid(rxa_valid), .rxa_data(rxa_data),
    .rxb_valid(rxb_valid), .rxb_data(rxb_data),
    .txa_stb(txa_stb), .txa_data(txa_data),
    .txb_stb(txb_stb), .txb_data(txb_data),
    .tick(tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx(input bit ch, input logic [7:0] d);
    if (ch) begin rxb_valid = 1'b1; rxb_data = d; end
    else    begin rxa_valid = 1'b1; rxa_data = d; end
    @(negedge clk);
    rxa_valid = 1'b0; rxb_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx strobes", {6'd0, txb_stb, txa_stb}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(16'h390, v); chk("R1 status", v, 8'h00);
    rd(16'h3A0, v); chk("R1 mask", v, 8'h00);
    rd(16'h120, v); chk("R1 pending A", v, 8'h04);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(16'h3A0, 8'hA5); rd(16'h3A0, v); chk("R2 full mask", v, 8'hA5);
    wr(16'h330, 8'h3C); rd(16'h3A0, v); chk("R3 low lane write", v, 8'hAC);
    rd(16'h330, v); chk("R3 low lane read", v, 8'h0C);
    wr(16'h350, 8'hF7); rd(16'h3A0, v); chk("R3 high lane write", v, 8'h7C);
    rd(16'h350, v); chk("R3 high lane read", v, 8'h07);
    wr(16'h3A0, 8'h00);
  endtask

  task automatic t_rx_masked();
    logic [7:0] v;
    rx(1'b0, 8'h41);
    chk("R6 no irq", {7'd0, irq}, 8'h00);
    rd(16'h390, v); chk("R6 no status", v, 8'h00);
    rd(16'h120, v); chk("R9 pending A", v, 8'h05);
    rd(16'h160, v); chk("R7 held byte", v, 8'h41);
    rd(16'h120, v); chk("R7 pending cleared", v, 8'h04);
  endtask

  task automatic t_rx_unmasked();
    logic [7:0] v;
    wr(16'h3A0, 8'h22);
    rx(1'b0, 8'h55);
    chk("R5 irq A", {7'd0, irq}, 8'h01);
    rd(16'h390, v); chk("R5 status A", v, 8'h02);
    rd(16'h320, v); chk("R4 lane A", v, 8'h02);
    rx(1'b1, 8'h66);
    rd(16'h390, v); chk("R5 status A+B", v, 8'h22);
    rd(16'h340, v); chk("R4 lane B", v, 8'h02);
    rd(16'h220, v); chk("R9 pending B", v, 8'h05);
    chk("R10 B read keeps irq", {7'd0, irq}, 8'h01);
    rd(16'h120, v); chk("R9 pending A", v, 8'h05);
    chk("R10 A read drops irq", {7'd0, irq}, 8'h00);
    rd(16'h160, v); chk("R7 data A", v, 8'h55);
    rd(16'h390, v); chk("R7 status after A read", v, 8'h20);
    rx(1'b1, 8'h70); rx(1'b1, 8'h71);
    rd(16'h260, v); chk("R7 overwrite", v, 8'h71);
    rd(16'h390, v); chk("R7 status cleared", v, 8'h00);
    rd(16'h220, v); chk("R7 B not pending", v, 8'h04);
    rd(16'h120, v);
  endtask

  task automatic t_tx_tick();
    logic [7:0] v;
    wr(16'h3A0, 8'h01);
    pulse_tick();
    chk("R11 first tick no irq", {7'd0, irq}, 8'h00);
    rd(16'h390, v); chk("R11 first tick no status", v, 8'h00);
    pulse_tick();
    chk("R11 second tick irq", {7'd0, irq}, 8'h01);
    rd(16'h390, v); chk("R11 both tx bits", v, 8'h11);
    rd(16'h120, v);
    wr(16'h170, 8'h5A);
    chk("R8 strobe A", {7'd0, txa_stb}, 8'h01);
    chk("R8 data A", txa_data, 8'h5A);
    chk("R8 no strobe B", {7'd0, txb_stb}, 8'h00);
    @(negedge clk);
    chk("R8 strobe A one cycle", {7'd0, txa_stb}, 8'h00);
    rd(16'h390, v); chk("R8 A tx bit cleared", v, 8'h10);
    wr(16'h270, 8'h33);
    chk("R8 strobe B", {7'd0, txb_stb}, 8'h01);
    chk("R8 data B", txb_data, 8'h33);
    rd(16'h390, v); chk("R8 B tx bit cleared", v, 8'h00);
    wr(16'h3A0, 8'h22);
    pulse_tick(); pulse_tick();
    chk("R11 no tx mask no irq", {7'd0, irq}, 8'h00);
    rd(16'h390, v); chk("R11 no tx mask no status", v, 8'h00);
    wr(16'h3A0, 8'h10);
    pulse_tick(); pulse_tick();
    rd(16'h390, v); chk("R11 B mask enables both", v, 8'h11);
    wr(16'h170, 8'h00); wr(16'h270, 8'h00); rd(16'h120, v);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(16'h3A0, 8'h12);
    wr(16'h0123, 8'hFF);
    rd(16'h3A0, v); chk("R12 stray write ignored", v, 8'h12);
    rd(16'h1A76, v); chk("R12 unmapped read", v, 8'h00);
    rd(16'h0100, v); chk("R12 mode addr read", v, 8'h00);
    rd(16'h0170, v); chk("R12 tx data read", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(16'h3A0, 8'h02);
    rx(1'b0, 8'h10);
    // read data A while a new byte arrives
    bus_addr = 16'h160; bus_rd = 1'b1; rxa_valid = 1'b1; rxa_data = 8'h20;
    @(negedge clk);
    bus_rd = 1'b0; rxa_valid = 1'b0;
    chk("R13 read returns older byte", bus_rdata, 8'h10);
    rd(16'h390, v); chk("R13 rx status kept", v, 8'h02);
    // channel A status read while a byte arrives
    bus_addr = 16'h120; bus_rd = 1'b1; rxa_valid = 1'b1; rxa_data = 8'h30;
    @(negedge clk);
    bus_rd = 1'b0; rxa_valid = 1'b0;
    chk("R13 irq kept", {7'd0, irq}, 8'h01);
    rd(16'h160, v); chk("R13 newest byte", v, 8'h30);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    rxa_valid = 1'b0; rxb_valid = 1'b0; rxa_data = '0; rxb_data = '0; tick = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_rx_masked();
    t_rx_unmasked();
    t_tx_tick();
    t_unmapped();
    t_collision();
    finish_run();
  end

  initial begin
    #(5ns * 50000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0x01 expected 0x00");
    finish_run();
  end
endmodule